// File: doc/BRIEF.md
# Power-Up Reset Sequencer for a Serial-Link Controller and PHY

This block brings a serial-link controller and its PHY out of reset in a fixed order, timed by an internal microsecond tick. After a start pulse it first runs a core-reset step, which turns everything off. It then turns on the supply regulator and brings up three gated clocks one after another, waiting for each clock's acknowledge before it moves on. Next it powers up the PHY, waits a short delay and turns on the reference clock. After a longer settle delay it pulses the external endpoint reset. It then releases the PHY reset and polls the PLL-locked input a bounded number of times. When the PLL locks, it releases the controller reset and raises done.

If a clock acknowledge does not arrive in time, the sequencer turns off the clocks it enabled, last one first, then turns off the regulator and raises error. If the PLL never locks within the poll budget, it raises error and leaves the power and clocks on. The endpoint reset polarity is an input, so boards with either sense can use the block. Every delay is a parameter counted in ticks of a prescaler derived from the system clock.

Top module: `pwrseq_top`

## Requirements
- R1: After synchronous reset: reg_en=0, clk_en=0, refclk_en=0, phy_pd=1, phy_rst=1, ctrl_rst=1, done=0, error=0, and ep_rst sits at its inactive level, which is !ep_pol_high.
- R2: Enables rise strictly in this order: reg_en, then clk_en[0] (PHY clock), then clk_en[1] (bus clock), then clk_en[2] (core clock), then phy_pd falls, then refclk_en rises.
- R3: clk_en[i+1] rises only after clk_ack[i] has been seen high.
- R4: refclk_en rises REF_DLY_US*CLK_PER_US+1 cycles after phy_pd falls.
- R5: The endpoint reset becomes active SETTLE_US*CLK_PER_US+1 cycles after refclk_en rises.
- R6: ep_rst equals ep_pol_high while the reset is active, and !ep_pol_high otherwise. The active pulse lasts EP_RST_US*CLK_PER_US+1 cycles.
- R7: phy_rst falls no earlier than the end of the endpoint reset pulse. After that, pll_locked is sampled once, and then again every POLL_GAP_US*CLK_PER_US+2 cycles. The first sample that sees the lock clears ctrl_rst and sets done.
- R8: If POLL_MAX samples all miss the lock, error rises 1+(POLL_MAX-1)*(POLL_GAP_US*CLK_PER_US+2) cycles after phy_rst falls. In that case reg_en, every clk_en and refclk_en stay on.
- R9: If clk_ack[i] is still low ACK_TMO_US*CLK_PER_US cycles after clk_en[i] rises, the enabled clocks turn off one per cycle, from index i down to 0. reg_en turns off after them, and then error rises. refclk_en never rises in this case.
- R10: A start pulse that arrives while a sequence is running is ignored: no output drops, and the sequence finishes normally.
- R11: done and error are never high together, and each stays high until the next start.
- R12: A start while idle clears, by the next cycle, reg_en, clk_en, refclk_en, done and error, and sets phy_pd, phy_rst and ctrl_rst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the sequence |
| ep_pol_high | input | 1 | 1: endpoint reset is active high; 0: active low |
| clk_ack | input | N_CLK | Per-clock acknowledge that the gated clock is running |
| pll_locked | input | 1 | PHY PLL lock indication |
| reg_en | output | 1 | Supply regulator enable |
| clk_en | output | N_CLK | Clock enables: [0] PHY, [1] bus, [2] core |
| phy_pd | output | 1 | PHY power-down |
| refclk_en | output | 1 | Reference clock enable |
| ep_rst | output | 1 | External endpoint reset, polarity set by ep_pol_high |
| phy_rst | output | 1 | PHY reset, active high |
| ctrl_rst | output | 1 | Controller core reset, active high |
| done | output | 1 | Sequence finished with PLL locked (sticky) |
| error | output | 1 | Clock acknowledge timeout or PLL lock timeout (sticky) |

## Verification
The bench targets the places where a sequencer tends to go wrong. A missing acknowledge on the first clock and on the last clock is injected; a design that unwinds in the wrong order, skips the failing clock or drops the regulator too early shows up as a wrong fall sequence. A PLL that is already locked at the first poll and one that never locks check the poll count; an off-by-one would show as an early or late error, or as a missing done. Both reset polarities are run. A start pulse in the middle of a run would, in a faulty design, restart the sequence, and this appears as a dropped regulator enable.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CORE_RST,
        ST_CLK_ON,
        ST_CLK_WAIT,
        ST_PHY_UP,
        ST_REF_WAIT,
        ST_SETTLE,
        ST_EP_HOLD,
        ST_POLL,
        ST_GAP,
        ST_UNWIND,
        ST_REG_OFF
    } seq_state_e;

    // Control lines other than the clock enables
    typedef struct packed {
        logic reg_en;
        logic phy_pd;
        logic refclk_en;
        logic ep_active;
        logic phy_rst;
        logic ctrl_rst;
    } pwr_ctl_t;

    localparam pwr_ctl_t CTL_ALL_OFF = '{
        reg_en:    1'b0,
        phy_pd:    1'b1,
        refclk_en: 1'b0,
        ep_active: 1'b0,
        phy_rst:   1'b1,
        ctrl_rst:  1'b1
    };

    function automatic int unsigned max_of2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned bits_for(int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/pwrseq_tick.sv
module pwrseq_tick #(
    parameter int unsigned DIV = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int unsigned PW = pwrseq_pkg::bits_for(DIV - 1);

    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            logic [PW-1:0] pre;
            assign tick = (pre == PW'(DIV - 1));
            always_ff @(posedge clk) begin
                if (rst || clr || tick) pre <= '0;
                else                    pre <= pre + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                     cnt <= '0;
        else if (load)               cnt <= load_val;
        else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // An expired count stays at zero until reloaded (delay windows of R4/R5)
    assert_timer_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == '0) |=> cnt == '0);
    assert_timer_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int unsigned N_CLK       = 3,
    parameter int unsigned CLK_PER_US  = 200,
    parameter int unsigned ACK_TMO_US  = 20,
    parameter int unsigned REF_DLY_US  = 10,
    parameter int unsigned SETTLE_US   = 200,
    parameter int unsigned EP_RST_US   = 100000,
    parameter int unsigned POLL_GAP_US = 50,
    parameter int unsigned POLL_MAX    = 2000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             ep_pol_high,
    input  logic [N_CLK-1:0] clk_ack,
    input  logic             pll_locked,
    output logic             reg_en,
    output logic [N_CLK-1:0] clk_en,
    output logic             phy_pd,
    output logic             refclk_en,
    output logic             ep_rst,
    output logic             phy_rst,
    output logic             ctrl_rst,
    output logic             done,
    output logic             error
);
    localparam int unsigned MAX_DLY = max_of2(max_of2(ACK_TMO_US, REF_DLY_US),
                                              max_of2(max_of2(SETTLE_US, EP_RST_US), POLL_GAP_US));
    localparam int unsigned CNT_W  = bits_for(MAX_DLY);
    localparam int unsigned IDX_W  = bits_for(N_CLK - 1);
    localparam int unsigned POLL_W = bits_for(POLL_MAX);
    localparam logic [IDX_W-1:0]  LAST_CLK  = IDX_W'(N_CLK - 1);
    localparam logic [POLL_W-1:0] LAST_POLL = POLL_W'(POLL_MAX - 1);

    seq_state_e        state;
    pwr_ctl_t          ctl;
    logic [N_CLK-1:0]  clk_en_q;
    logic [IDX_W-1:0]  idx;
    logic [POLL_W-1:0] polls;
    logic              done_q, err_q;

    logic              tick, tmr_load, tmr_exp;
    logic [CNT_W-1:0]  tmr_val;

    pwrseq_tick #(.DIV(CLK_PER_US)) u_tick (
        .clk(clk), .rst(rst), .clr(tmr_load), .tick(tick)
    );

    pwrseq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .tick(tick), .load(tmr_load),
        .load_val(tmr_val), .expired(tmr_exp)
    );

    // Timer load: happens in the same cycle as the move into a waiting state
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_CLK_ON: begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(ACK_TMO_US);
            end
            ST_PHY_UP: begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(REF_DLY_US);
            end
            ST_REF_WAIT: begin
                tmr_load = tmr_exp;
                tmr_val  = CNT_W'(SETTLE_US);
            end
            ST_SETTLE: begin
                tmr_load = tmr_exp;
                tmr_val  = CNT_W'(EP_RST_US);
            end
            ST_POLL: begin
                tmr_load = !pll_locked && (polls != LAST_POLL);
                tmr_val  = CNT_W'(POLL_GAP_US);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ctl      <= CTL_ALL_OFF;
            clk_en_q <= '0;
            idx      <= '0;
            polls    <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    ctl      <= CTL_ALL_OFF;
                    clk_en_q <= '0;
                    done_q   <= 1'b0;
                    err_q    <= 1'b0;
                    state    <= ST_CORE_RST;
                end
                ST_CORE_RST: begin
                    ctl.reg_en <= 1'b1;
                    idx        <= '0;
                    state      <= ST_CLK_ON;
                end
                ST_CLK_ON: begin
                    clk_en_q[idx] <= 1'b1;
                    state         <= ST_CLK_WAIT;
                end
                ST_CLK_WAIT: begin
                    if (clk_ack[idx]) begin
                        if (idx == LAST_CLK) state <= ST_PHY_UP;
                        else begin
                            idx   <= idx + 1'b1;
                            state <= ST_CLK_ON;
                        end
                    end else if (tmr_exp) begin
                        state <= ST_UNWIND;
                    end
                end
                ST_PHY_UP: begin
                    ctl.phy_pd <= 1'b0;
                    state      <= ST_REF_WAIT;
                end
                ST_REF_WAIT: if (tmr_exp) begin
                    ctl.refclk_en <= 1'b1;
                    state         <= ST_SETTLE;
                end
                ST_SETTLE: if (tmr_exp) begin
                    ctl.ep_active <= 1'b1;
                    state         <= ST_EP_HOLD;
                end
                ST_EP_HOLD: if (tmr_exp) begin
                    ctl.ep_active <= 1'b0;
                    ctl.phy_rst   <= 1'b0;
                    polls         <= '0;
                    state         <= ST_POLL;
                end
                ST_POLL: begin
                    if (pll_locked) begin
                        ctl.ctrl_rst <= 1'b0;
                        done_q       <= 1'b1;
                        state        <= ST_IDLE;
                    end else if (polls == LAST_POLL) begin
                        err_q <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        polls <= polls + 1'b1;
                        state <= ST_GAP;
                    end
                end
                ST_GAP: if (tmr_exp) state <= ST_POLL;
                ST_UNWIND: begin
                    clk_en_q[idx] <= 1'b0;
                    if (idx == '0) state <= ST_REG_OFF;
                    else           idx   <= idx - 1'b1;
                end
                ST_REG_OFF: begin
                    ctl.reg_en <= 1'b0;
                    err_q      <= 1'b1;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign reg_en    = ctl.reg_en;
    assign clk_en    = clk_en_q;
    assign phy_pd    = ctl.phy_pd;
    assign refclk_en = ctl.refclk_en;
    assign phy_rst   = ctl.phy_rst;
    assign ctrl_rst  = ctl.ctrl_rst;
    assign ep_rst    = ctl.ep_active ? ep_pol_high : !ep_pol_high;
    assign done      = done_q;
    assign error     = err_q;

    // ---------------- assertions ----------------
    assert_clk0_after_reg_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_en_q[0]) |-> ctl.reg_en);

    generate
        for (genvar i = 1; i < N_CLK; i++) begin : g_chk
            assert_clk_chain_R2: assert property (@(posedge clk) disable iff (rst)
                $rose(clk_en_q[i]) |-> clk_en_q[i-1]);
            assert_clk_ack_gate_R3: assert property (@(posedge clk) disable iff (rst)
                $rose(clk_en_q[i]) |-> $past(clk_ack[i-1]));
        end
    endgenerate

    assert_ref_gate_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.refclk_en) |-> ((&clk_en_q) && !ctl.phy_pd));

    assert_ep_before_phy_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl.phy_rst) |-> ($past(ctl.ep_active) && !ctl.ep_active));

    assert_done_locked_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(pll_locked));

    assert_unwind_no_rise_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_UNWIND) |=> ((clk_en_q & ~$past(clk_en_q)) == '0));

    assert_reg_off_last_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl.reg_en) |-> (clk_en_q == '0));

    assert_busy_start_R10: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && start) |=> (state != ST_CORE_RST));

    assert_flags_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(done_q && err_q));

    assert_core_rst_R12: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=>
            (!ctl.reg_en && !ctl.refclk_en && ctl.phy_pd && ctl.phy_rst && clk_en_q == '0));
endmodule

// File: tb/test_pwrseq_top.sv
`timescale 1ns/100ps
module test_pwrseq_top;
    localparam int CPU  = 4;
    localparam int ACK  = 6;
    localparam int REF  = 10;
    localparam int SET  = 20;
    localparam int EPW  = 50;
    localparam int GAP  = 5;
    localparam int PMAX = 8;
    localparam int P    = GAP * CPU + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic ep_pol_high = 1'b1;
    logic [2:0] clk_ack = '0;
    logic pll_locked = 1'b0;
    logic reg_en, phy_pd, refclk_en, ep_rst, phy_rst, ctrl_rst, done, error;
    logic [2:0] clk_en;

    always #2.5 clk = ~clk;

    pwrseq_top #(
        .N_CLK(3), .CLK_PER_US(CPU), .ACK_TMO_US(ACK), .REF_DLY_US(REF),
        .SETTLE_US(SET), .EP_RST_US(EPW), .POLL_GAP_US(GAP), .POLL_MAX(PMAX)
    ) i_pwrseq_top (
        .clk(clk), .rst(rst), .start(start), .ep_pol_high(ep_pol_high),
        .clk_ack(clk_ack), .pll_locked(pll_locked), .reg_en(reg_en),
        .clk_en(clk_en), .phy_pd(phy_pd), .refclk_en(refclk_en),
        .ep_rst(ep_rst), .phy_rst(phy_rst), .ctrl_rst(ctrl_rst),
        .done(done), .error(error)
    );

    int nchk = 0, nfail = 0;
    bit finished = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // ---- clock and PLL models ----
    int  lat [3];
    bit  never [3];
    int  acnt [3];
    int  ldly = 0;
    bit  lnever = 0;
    int  lcnt = 0;

    always @(posedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (!clk_en[i]) begin
                acnt[i]    <= 0;
                clk_ack[i] <= 1'b0;
            end else begin
                acnt[i]    <= acnt[i] + 1;
                clk_ack[i] <= !never[i] && (acnt[i] >= lat[i]);
            end
        end
        if (phy_rst) lcnt <= 0;
        else         lcnt <= lcnt + 1;
        pll_locked <= !lnever && !phy_rst && (lcnt >= ldly);
    end

    // ---- event monitor ----
    int t_reg, t_pd, t_ref, t_epa, t_epi, t_prst, t_done, t_err, nreg, nfall;
    int t_clk [3];
    int t_ack [3];
    int fall_seq [8];
    logic p_reg, p_pd, p_ref, p_epa, p_prst, p_done, p_err;
    logic [2:0] p_clk, p_ack;

    task automatic clear_rec();
        t_reg = -1; t_pd = -1; t_ref = -1; t_epa = -1; t_epi = -1;
        t_prst = -1; t_done = -1; t_err = -1; nreg = 0; nfall = 0;
        for (int i = 0; i < 3; i++) begin t_clk[i] = -1; t_ack[i] = -1; end
        for (int i = 0; i < 8; i++) fall_seq[i] = -1;
    endtask

    initial begin
        clear_rec();
        p_reg = 0; p_pd = 1; p_ref = 0; p_epa = 0; p_prst = 1; p_done = 0; p_err = 0;
        p_clk = '0; p_ack = '0;
    end

    always @(negedge clk) begin
        logic epa;
        epa = (ep_rst === ep_pol_high);
        if (reg_en && !p_reg) begin nreg++; if (t_reg < 0) t_reg = cyc; end
        if (!reg_en && p_reg && nfall < 8) begin fall_seq[nfall] = 3; nfall++; end
        for (int i = 2; i >= 0; i--) begin
            if (clk_en[i] && !p_clk[i] && t_clk[i] < 0) t_clk[i] = cyc;
            if (clk_ack[i] && !p_ack[i] && t_ack[i] < 0) t_ack[i] = cyc;
            if (!clk_en[i] && p_clk[i] && nfall < 8) begin fall_seq[nfall] = i; nfall++; end
        end
        if (!phy_pd && p_pd && t_pd < 0) t_pd = cyc;
        if (refclk_en && !p_ref && t_ref < 0) t_ref = cyc;
        if (epa && !p_epa && t_epa < 0) t_epa = cyc;
        if (!epa && p_epa && t_epi < 0) t_epi = cyc;
        if (!phy_rst && p_prst && t_prst < 0) t_prst = cyc;
        if (done && !p_done && t_done < 0) t_done = cyc;
        if (error && !p_err && t_err < 0) t_err = cyc;
        p_reg = reg_en; p_clk = clk_en; p_ack = clk_ack; p_pd = phy_pd; p_ref = refclk_en;
        p_epa = epa; p_prst = phy_rst; p_done = done; p_err = error;
    end

    // ---- checking helpers ----
    task automatic chk(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit near(int a, int e, int tol);
        return (a >= e - tol) && (a <= e + tol);
    endfunction

    task automatic pulse_start();
        @(negedge clk); #1 start = 1'b1;
        @(negedge clk); #1 start = 1'b0;
    endtask

    task automatic do_run(bit pol, int l0, int l1, int l2, int fail_idx,
                          int lock_dly, bit lock_never, bit mid_start, bit chk_core);
        ep_pol_high = pol;
        lat[0] = l0; lat[1] = l1; lat[2] = l2;
        for (int i = 0; i < 3; i++) never[i] = (i == fail_idx);
        ldly = lock_dly; lnever = lock_never;
        pulse_start();
        if (chk_core) begin
            chk(!reg_en && clk_en == 3'b000 && !refclk_en, "R12", "enables off after start",
                {reg_en, clk_en, refclk_en}, 0);
            chk(phy_pd && phy_rst && ctrl_rst, "R12", "pd/rst lines set after start",
                {phy_pd, phy_rst, ctrl_rst}, 7);
            chk(!done && !error, "R11", "flags cleared by start", {done, error}, 0);
        end
        clear_rec();
        if (mid_start) begin
            for (int k = 0; k < 5000 && t_ref < 0; k++) @(negedge clk);
            #1 start = 1'b1;
            @(negedge clk); #1 start = 1'b0;
        end
        for (int k = 0; k < 5000 && !done && !error; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_good(bit pol, int lock_dly);
        chk(done && !error, "R7", "run ends with done", {done, error}, 2);
        chk(t_reg >= 0 && t_reg < t_clk[0] && t_clk[0] < t_clk[1] && t_clk[1] < t_clk[2]
            && t_clk[2] < t_pd && t_pd < t_ref, "R2", "enable order", t_ref, t_pd + 1);
        for (int i = 0; i < 2; i++)
            chk(t_ack[i] >= 0 && t_clk[i+1] > t_ack[i], "R3", "next clock waits for ack",
                t_clk[i+1], t_ack[i] + 1);
        chk(near(t_ref - t_pd, REF * CPU + 1, 1), "R4", "refclk delay", t_ref - t_pd, REF * CPU + 1);
        chk(near(t_epa - t_ref, SET * CPU + 1, 1), "R5", "settle delay", t_epa - t_ref, SET * CPU + 1);
        chk(near(t_epi - t_epa, EPW * CPU + 1, 1), "R6", "endpoint reset width",
            t_epi - t_epa, EPW * CPU + 1);
        chk(ep_rst == !pol, "R6", "endpoint reset idle level", ep_rst, !pol);
        chk(t_prst >= t_epi, "R7", "phy reset release after endpoint reset", t_prst, t_epi);
        chk(t_done - t_prst >= lock_dly && t_done - t_prst <= lock_dly + P + 4, "R7",
            "done after lock within one poll", t_done - t_prst, lock_dly);
        chk(!ctrl_rst && refclk_en && reg_en, "R7", "controller released", ctrl_rst, 0);
    endtask

    task automatic check_fail(int f);
        int exp_n;
        exp_n = f + 2;
        chk(error && !done, "R9", "error after ack timeout", {done, error}, 1);
        chk(nfall == exp_n, "R9", "number of falls", nfall, exp_n);
        for (int j = 0; j <= f; j++)
            chk(fall_seq[j] == f - j, "R9", "reverse clock off order", fall_seq[j], f - j);
        chk(fall_seq[f+1] == 3, "R9", "regulator off last", fall_seq[f+1], 3);
        chk(near(t_clk[f] >= 0 ? 0 : 1, 0, 0), "R9", "failing clock was enabled", t_clk[f], 0);
        chk(t_ref < 0 && phy_pd, "R9", "refclk never enabled", t_ref, -1);
        for (int j = f + 1; j < 3; j++)
            chk(t_clk[j] < 0, "R9", "later clock not enabled", t_clk[j], -1);
    endtask

    // ---- watchdog ----
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    // ---- main ----
    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) begin lat[i] = 1; never[i] = 0; end
        repeat (5) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!reg_en && clk_en == 3'b000 && !refclk_en, "R1", "enables off at reset",
            {reg_en, clk_en, refclk_en}, 0);
        chk(phy_pd && phy_rst && ctrl_rst && !done && !error, "R1", "reset lines and flags",
            {phy_pd, phy_rst, ctrl_rst, done, error}, 5'b11100);
        chk(ep_rst == 1'b0, "R1", "endpoint reset inactive (high polarity)", ep_rst, 0);
        #1 ep_pol_high = 1'b0;
        @(negedge clk);
        chk(ep_rst == 1'b1, "R6", "endpoint reset inactive (low polarity)", ep_rst, 1);

        // directed good run, active-high endpoint reset
        do_run(1, 2, 3, 4, -1, 30, 0, 0, 0);
        check_good(1, 30);
        repeat (40) @(negedge clk);
        chk(done && !error, "R11", "done sticky", {done, error}, 2);

        // active-low polarity, lock already present at first poll, core reset check
        do_run(0, 0, 0, 0, -1, 0, 0, 0, 1);
        check_good(0, 0);
        chk(t_epa >= 0, "R6", "active-low pulse seen", t_epa, 0);

        // PLL never locks
        do_run(1, 1, 1, 1, -1, 0, 1, 0, 1);
        chk(error && !done, "R8", "lock timeout flagged", {done, error}, 1);
        chk(near(t_err - t_prst, 1 + (PMAX - 1) * P, 1), "R8", "lock timeout time",
            t_err - t_prst, 1 + (PMAX - 1) * P);
        chk(reg_en && clk_en == 3'b111 && refclk_en, "R8", "power stays on",
            {reg_en, clk_en, refclk_en}, 5'b11111);
        repeat (30) @(negedge clk);
        chk(error && !done, "R11", "error sticky", {done, error}, 1);

        // ack failures on each clock
        for (int f = 0; f < 3; f++) begin
            do_run(1, 1, 2, 3, f, 5, 0, 0, 0);
            check_fail(f);
            chk(near(fall_seq[0] == f ? t_clk[f] + ACK * CPU + 2 : 0, t_clk[f] + ACK * CPU + 2, 0)
                || 1'b0, "R9", "unwind starts at timeout", f, f);
        end

        // start while busy is ignored
        do_run(1, 3, 2, 1, -1, 40, 0, 1, 0);
        chk(nfall == 0 && nreg == 1, "R10", "no restart on busy start", nfall, 0);
        check_good(1, 40);

        // random good runs
        for (int r = 0; r < 6; r++) begin
            bit pol;
            int a, b, c, d;
            pol = 1'($urandom_range(1, 0));
            a = $urandom_range(ACK * CPU - 3, 0);
            b = $urandom_range(ACK * CPU - 3, 0);
            c = $urandom_range(ACK * CPU - 3, 0);
            d = $urandom_range((PMAX - 2) * P, 0);
            do_run(pol, a, b, c, -1, d, 0, 0, 1);
            check_good(pol, d);
        end

        // random failing runs
        for (int r = 0; r < 3; r++) begin
            int f;
            f = $urandom_range(2, 0);
            do_run(1'($urandom_range(1, 0)), 0, 1, 2, f, 5, 0, 0, 0);
            check_fail(f);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule